// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is the target side of a two-wire serial EEPROM. It watches the SCL and SDA lines and pulls SDA low through an open-drain enable. It recognises START, repeated START and STOP, and answers a select byte made of a fixed 1010 prefix, one strap bit, two block bits and a direction bit. Behind the bus sits a byte array of 2^ADDR_W locations, reached through one address pointer. The block bits of the select byte form the top of that pointer and the word-address byte forms the low eight bits.

Writes store bytes one after another inside a single page, folding back to the start of that page. Reads stream bytes from the pointer for as long as the controller keeps acknowledging, and run across the whole array. When a STOP closes a transaction that stored data, the block imitates the self-timed programming cycle of a real part. For BUSY_CLKS system clocks it leaves every select byte unacknowledged. A testbench can set BUSY_CLKS low to keep runs short.

Top module: `i2c_ee_target`

## Requirements
- R1: START is SDA falling while SCL is high and STOP is SDA rising while SCL is high. Either condition arriving part-way through a byte abandons that byte. A data byte that has not been acknowledged is never stored.
- R2: A select byte is acknowledged only if bits 7..4 are 1010 and bit 3 equals a2_i. Bits 2..1 are the block, and bit 0 is the direction (1 = read). On any other select byte SDA stays released and the rest of the transaction is ignored until the next START.
- R3: The target pulls SDA low on the 9th SCL pulse after an accepted select byte, after a word-address byte, and after each write data byte.
- R4: A write transaction stores each data byte at address {block, word}. The write select sets the block and the following byte sets the word.
- R5: During a write, only the low 4 address bits advance. Writing more than 16 bytes wraps within the same 16-byte page and overwrites its first locations.
- R6: A random read is a write select plus a word address, then a repeated START, then a read select carrying the block bits. After that the target sends the stored byte MSB first.
- R7: After each byte it sends, the target advances the full 10-bit address. Reading past location 0x3FF continues at 0x000.
- R8: If SDA is high on the 9th pulse of a read byte, the target releases SDA and sends nothing more until the next START.
- R9: After a STOP that ends a transaction with at least one stored byte, select bytes are not acknowledged for BUSY_CLKS clocks. After that they are acknowledged again. A transaction that stored nothing starts no busy window.
- R10: The SDA drive enable changes only in response to an SCL falling edge, a START or a STOP.
- R11: After reset the target does not drive SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| a2_i | input | 1 | Strapped address bit compared with select bit 3 |
| sda_oe_o | output | 1 | High to pull SDA low, low to release it |

## Verification
A START or a STOP can land in the same synchroniser cycle as the SCL edge that shifts a bit into a partly received write byte. The abort must then take priority over the shift and over any store. The bench sets up this case by sending four bits of a data byte and then a repeated START, and later by ending a word-address byte three bits in with a STOP. The result is judged at the ports: a fresh select byte is acknowledged at once (so no busy window was started), and reading back the target location returns its earlier contents.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam logic [3:0] SEL_PREFIX = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } ee_state_e;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_STAGES-1];
      sda_q  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_ff[SYNC_STAGES-1];
  assign sda_o      = sda_ff[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_ee_busy.sv
module i2c_ee_busy #(
  parameter int BUSY_CLKS = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CLKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt <= '0;
    else if (load_i)      cnt <= CW'(BUSY_CLKS);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  assert_busy_from_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(load_i));
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 2 ** ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 4,
  parameter int BUSY_CLKS   = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic a2_i,
  output logic sda_oe_o
);
  localparam int BLK_W = ADDR_W - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, mem_we, sel_hit, rx_state, wrote, ack_ok, rw;
  logic [3:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh, rd_data;
  logic [ADDR_W-1:0] addr;
  ee_state_e state;

  i2c_ee_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_ee_busy #(.BUSY_CLKS(BUSY_CLKS)) u_busy (
    .clk_i, .rst_ni, .load_i(stop_det & wrote), .busy_o(busy)
  );

  i2c_ee_mem #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk_i, .we_i(mem_we), .waddr_i(addr), .wdata_i(rx_sh),
    .raddr_i(addr), .rdata_o(rd_data)
  );

  assign rx_state = (state == ST_DEV) || (state == ST_ADDR) || (state == ST_WDATA);
  assign sel_hit  = (rx_sh[7:4] == SEL_PREFIX) && (rx_sh[3] == a2_i) && !busy;
  assign mem_we   = scl_fall && (state == ST_WDATA_ACK) && !start_det && !stop_det;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      addr    <= '0;
      rw      <= 1'b0;
      wrote   <= 1'b0;
      ack_ok  <= 1'b0;
    end else if (start_det) begin
      state   <= ST_DEV;
      bit_cnt <= '0;
    end else if (stop_det) begin
      state <= ST_IDLE;
      wrote <= 1'b0;
    end else begin
      if (scl_rise) begin
        if (rx_state) begin
          rx_sh   <= {rx_sh[6:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (state == ST_RACK) ack_ok <= !sda_s;
      end
      if (scl_fall) begin
        unique case (state)
          ST_DEV: if (bit_cnt == 4'd8) begin
            if (sel_hit) begin
              state <= ST_DEV_ACK;
              rw    <= rx_sh[0];
              addr[ADDR_W-1:8] <= rx_sh[BLK_W:1];
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_DEV_ACK: begin
            bit_cnt <= '0;
            if (rw) begin
              tx_sh <= rd_data;
              addr  <= addr + 1'b1;
              state <= ST_RDATA;
            end else begin
              state <= ST_ADDR;
            end
          end
          ST_ADDR: if (bit_cnt == 4'd8) begin
            addr[7:0] <= rx_sh;
            state     <= ST_ADDR_ACK;
          end
          ST_ADDR_ACK: begin
            bit_cnt <= '0;
            state   <= ST_WDATA;
          end
          ST_WDATA: if (bit_cnt == 4'd8) state <= ST_WDATA_ACK;
          ST_WDATA_ACK: begin
            // store happens via mem_we; only the in-page bits advance
            addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
            wrote   <= 1'b1;
            bit_cnt <= '0;
            state   <= ST_WDATA;
          end
          ST_RDATA: begin
            if (bit_cnt == 4'd7) begin
              state <= ST_RACK;
            end else begin
              tx_sh   <= {tx_sh[6:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_RACK: begin
            if (ack_ok) begin
              tx_sh   <= rd_data;
              addr    <= addr + 1'b1;
              bit_cnt <= '0;
              state   <= ST_RDATA;
            end else begin
              state <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_DEV_ACK, ST_ADDR_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
      ST_RDATA:                              sda_oe_o = !tx_sh[7];
      default:                               sda_oe_o = 1'b0;
    endcase
  end

  assert_oe_after_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(scl_fall | start_det | stop_det));

  assert_idle_released_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> !sda_oe_o);

  assert_page_fixed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));

  assert_seq_advance_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_fall && state == ST_RACK && ack_ok && !start_det && !stop_det)
      |=> addr == ADDR_W'($past(addr) + 1'b1));

  assert_busy_nack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && scl_fall && state == ST_DEV && bit_cnt == 4'd8) |=> state == ST_IDLE);
endmodule

// File: tb/i2c_ee_target_tb_top.sv
module i2c_ee_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int BUSY       = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_drv = 1'b1;
  logic a2 = 1'b1;
  logic sda_oe;
  logic sda_bus;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [1024];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_drv & ~sda_oe;

  i2c_ee_target #(.BUSY_CLKS(BUSY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .a2_i(a2), .sda_oe_o(sda_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin : mon
    logic [7:0] g, e;
    string t;
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(g === e, t, g, e);
    end
  end

  task automatic qwait(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic send_start();
    sda_drv = 1'b1; qwait(1);
    scl = 1'b1;     qwait(2);
    sda_drv = 1'b0; qwait(2);
    scl = 1'b0;     qwait(1);
  endtask

  task automatic send_stop();
    sda_drv = 1'b0; qwait(1);
    scl = 1'b1;     qwait(2);
    sda_drv = 1'b1; qwait(2);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_drv = b; qwait(1);
    scl = 1'b1;  qwait(1);
    s = sda_bus; qwait(1);
    scl = 1'b0;  qwait(1);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(!give_ack, s);
  endtask

  task automatic do_sel(input logic [7:0] b, input bit exp_ack, input string tag);
    logic a;
    wr_byte(b, a);
    check(a == exp_ack, tag, a, exp_ack);
  endtask

  function automatic logic [7:0] sel(input logic [1:0] blk, input logic rd);
    return {4'b1010, 1'b1, blk, rd};
  endfunction

  task automatic page_write(input logic [9:0] a, input int n, input logic [7:0] seed);
    logic ack;
    logic [7:0] v;
    send_start();
    do_sel(sel(a[9:8], 1'b0), 1'b1, "R3 write select ack");
    wr_byte(a[7:0], ack);
    check(ack, "R3 word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      v = seed ^ 8'(i * 8'h13);
      wr_byte(v, ack);
      check(ack, "R3 data byte ack", ack, 1);
      model[{a[9:4], 4'(a[3:0] + i)}] = v;
    end
    send_stop();
  endtask

  task automatic rand_read(input logic [9:0] a, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    send_start();
    do_sel(sel(a[9:8], 1'b0), 1'b1, "R6 dummy write select");
    wr_byte(a[7:0], ack);
    check(ack, "R6 dummy address ack", ack, 1);
    send_start();
    do_sel(sel(a[9:8], 1'b1), 1'b1, "R6 read select");
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[10'(a + i)]);
      tag_q.push_back(tag);
      rd_byte(i != n - 1, d);
      got_q.push_back(d);
    end
    send_stop();
  endtask

  task automatic wait_busy();
    repeat (BUSY + 100) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic s, ack;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R11 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(sda_oe == 1'b0, "R11 released after reset", sda_oe, 0);

    // R4/R9: store two bytes in block 2, probe busy, then read back
    page_write(10'h210, 2, 8'h88);
    send_start();
    do_sel(sel(2'd2, 1'b0), 1'b0, "R9 select refused while busy");
    send_stop();
    wait_busy();
    rand_read(10'h210, 1, "R4 R6 byte write readback");

    // R8: controller NAKs, target must stay quiet
    send_start();
    do_sel(sel(2'd2, 1'b0), 1'b1, "R9 select acked after busy");
    wr_byte(8'h10, ack);
    send_start();
    do_sel(sel(2'd2, 1'b1), 1'b1, "R6 read select");
    exp_q.push_back(8'h88); tag_q.push_back("R8 byte before nak");
    rd_byte(1'b0, d);
    got_q.push_back(d);
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s);
      check(s == 1'b1, "R8 SDA released after nak", s, 1);
    end
    send_stop();

    // R2: mismatching select bytes
    send_start();
    do_sel(8'hA0, 1'b0, "R2 strap bit mismatch");
    do_sel(8'h00, 1'b0, "R2 rest ignored");
    send_stop();
    send_start();
    do_sel(8'hB8, 1'b0, "R2 prefix mismatch");
    send_stop();

    // R5: 18 bytes from 0x005 wrap in page 0
    page_write(10'h005, 18, 8'h21);
    wait_busy();
    rand_read(10'h000, 16, "R5 R7 page wrap readback");

    // R7: read across the top of the array
    page_write(10'h3FF, 1, 8'h5A);
    wait_busy();
    rand_read(10'h3FF, 2, "R7 wrap 3FF to 000");

    // R1: mid-byte START and STOP abort without storing
    page_write(10'h020, 1, 8'h77);
    wait_busy();
    send_start();
    do_sel(sel(2'd0, 1'b0), 1'b1, "R1 select");
    wr_byte(8'h20, ack);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
    send_start();
    do_sel(sel(2'd0, 1'b0), 1'b1, "R1 mid-byte START restarts");
    for (int i = 0; i < 3; i++) clk_bit(1'b1, s);
    send_stop();
    send_start();
    do_sel(sel(2'd0, 1'b0), 1'b1, "R1 R9 no busy after aborted write");
    send_stop();
    rand_read(10'h020, 1, "R1 aborted byte not stored");

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule